// File: doc/BRIEF.md
# Shared Sense-Amplifier Bank State Tracker

This block follows a stream of already-decoded row commands aimed at a DRAM with a split-bank core. It keeps the open or closed state of every bank and the row each open bank holds. It reports which banks are using each sense amplifier. It also flags commands that break the sharing rule or the row-timing rules. The banks form two halves. Inside a half, two neighbouring banks share the amplifier that sits between them, so both cannot be open at once. Each half also has an unshared amplifier at each of its two ends, so the last bank of the lower half and the first bank of the upper half never conflict.

One command arrives per cycle: an activate or a precharge, with a bank number and, for an activate, a row. Each rule broken gives a one-cycle pulse that carries a rule code and the bank number. When one command breaks several rules, the lowest code wins. A separate pulse reports a bank that has stayed open past the maximum open time. All timing limits are parameters in cycles, so one netlist can serve several speed grades.

Top module: `bank_sa_tracker`

## Requirements
- R1: After reset all banks are closed, no pulse is raised, and every interval counts as already met, so any first command is legal.
- R2: An activate to a closed bank with both same-half neighbours closed opens the bank from the next cycle and stores its row. The row is visible on `qry_open_row` while `qry_bank` selects that bank.
- R3: An activate to a bank that is already open gives code 1. The bank stays open and its stored row does not change.
- R4: An activate to a bank whose neighbour in the same half is open gives code 2 and leaves the bank closed. The banks NUM_BANKS/2-1 and NUM_BANKS/2 are not neighbours. Two neighbouring banks in a half are never open together.
- R5: A precharge closes an open bank from the next cycle. A precharge to a closed bank raises no pulse, changes no state and does not restart any interval.
- R6: An activate less than T_RP cycles after that bank's last precharge gives code 3. The activate still takes effect.
- R7: An activate less than T_RC cycles after that bank's last accepted activate gives code 4. The activate still takes effect.
- R8: An accepted activate less than T_RR cycles after the previous accepted activate to any bank gives code 5.
- R9: A precharge less than T_RAS cycles after that bank's activate gives code 6. The bank still closes.
- R10: A precharge to an open bank less than T_PP cycles after the previous effective precharge gives code 7.
- R11: When several rules apply, the lowest code is reported. Codes 1 to 5 apply only to activates and codes 6 and 7 only to precharges.
- R12: A bank that has been open for exactly T_OPEN_MAX cycles raises `tmo_vld` for one cycle, with its index on `tmo_bank`. If several banks qualify, the lowest index is reported.
- R13: Amplifier `a` belongs to half h=a/(NUM_BANKS/2+1) and has local index k=a%(NUM_BANKS/2+1). It lies below local bank k and above local bank k-1 of that half. `sa_used[a]` is set when either of these banks is open. `sa_hi[a]` is set when the bank above it, local bank k, is open.
- R14: Violation pulses are registered and appear in the cycle after the command, carrying the command's bank number. A cycle with no command gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | A command is present this cycle |
| cmd_act | input | 1 | 1 = activate, 0 = precharge |
| cmd_bank | input | $clog2(NUM_BANKS) | Target bank |
| cmd_row | input | ROW_W | Row to open, used by activates only |
| qry_bank | input | $clog2(NUM_BANKS) | Bank whose stored row is shown |
| bank_open | output | NUM_BANKS | Open flag for each bank |
| qry_open_row | output | ROW_W | Stored row of `qry_bank` |
| sa_used | output | NUM_BANKS+2 | Amplifier held by an open bank |
| sa_hi | output | NUM_BANKS+2 | Amplifier held by the bank above it |
| viol_vld | output | 1 | One-cycle rule-violation pulse |
| viol_code | output | 4 | Code of the rule broken (1 to 7) |
| viol_bank | output | $clog2(NUM_BANKS) | Bank of the offending command |
| tmo_vld | output | 1 | One-cycle open-too-long pulse |
| tmo_bank | output | $clog2(NUM_BANKS) | Bank that has reached the open limit |

## Verification
The bench targets four corner cases. The first is the boundary between the two halves: a design that treats banks 15 and 16 as neighbours would reject a legal activate there. The second is a rejected activate: a design that restarts the activate interval or overwrites the row on such a command would later report false tRC or tRR violations, or return the wrong row. The third is a precharge to an already closed bank: if that precharge restarted the interval counters, later precharges and activates would be flagged wrongly. The fourth is a command that breaks several rules at once, where reporting anything but the lowest code is a failure. The bench also covers a tRC violation on its own, using a T_RC larger than T_RAS+T_RP, and checks that the open-time pulse fires exactly once.

// File: rtl/bt_pkg.sv
package bt_pkg;
   typedef enum logic [3:0] {
      V_NONE   = 4'd0,
      V_REOPEN = 4'd1,
      V_NEIGH  = 4'd2,
      V_TRP    = 4'd3,
      V_TRC    = 4'd4,
      V_TRR    = 4'd5,
      V_TRAS   = 4'd6,
      V_TPP    = 4'd7
   } viol_e;
endpackage

// File: rtl/bt_interval.sv
// Saturating count of cycles since the last restart; reset leaves it saturated.
module bt_interval #(
   parameter int unsigned SAT = 8,
   parameter int unsigned W   = $clog2(SAT + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   output logic [W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 count <= W'(SAT);
      else if (restart)           count <= W'(1);
      else if (count != W'(SAT))  count <= count + 1'b1;
   end
endmodule

// File: rtl/bt_bank_slot.sv
// One bank: open flag, stored row and the two per-bank intervals.
module bt_bank_slot #(
   parameter int unsigned ROW_W = 10,
   parameter int unsigned SAT   = 8,
   parameter int unsigned W     = $clog2(SAT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_act,
   input  logic             do_pre,
   input  logic [ROW_W-1:0] row_in,
   output logic             is_open,
   output logic [ROW_W-1:0] row_q,
   output logic [W-1:0]     since_act,
   output logic [W-1:0]     since_pre
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         is_open <= 1'b0;
         row_q   <= '0;
      end else if (do_act) begin
         is_open <= 1'b1;
         row_q   <= row_in;
      end else if (do_pre) begin
         is_open <= 1'b0;
      end
   end

   bt_interval #(.SAT(SAT), .W(W)) u_act (
      .clk(clk), .rst_n(rst_n), .restart(do_act), .count(since_act));
   bt_interval #(.SAT(SAT), .W(W)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(do_pre), .count(since_pre));
endmodule

// File: rtl/bt_amp_map.sv
// Neighbour-busy and sense-amplifier ownership for a two-half split-bank core.
module bt_amp_map #(
   parameter int unsigned NUM_BANKS = 32
) (
   input  logic [NUM_BANKS-1:0] bank_open,
   output logic [NUM_BANKS-1:0] nbr_busy,
   output logic [NUM_BANKS+1:0] sa_used,
   output logic [NUM_BANKS+1:0] sa_hi
);
   localparam int unsigned HALF = NUM_BANKS / 2;
   localparam int unsigned SPH  = HALF + 1;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int unsigned J = b % HALF;
      logic lo_n, hi_n;
      if (J == 0) begin : g_lo_edge
         assign lo_n = 1'b0;
      end else begin : g_lo
         assign lo_n = bank_open[b-1];
      end
      if (J == HALF - 1) begin : g_hi_edge
         assign hi_n = 1'b0;
      end else begin : g_hi
         assign hi_n = bank_open[b+1];
      end
      assign nbr_busy[b] = lo_n | hi_n;
   end

   for (genvar a = 0; a < NUM_BANKS + 2; a++) begin : g_amp
      localparam int unsigned H = a / SPH;
      localparam int unsigned K = a % SPH;
      logic below, above;
      if (K == 0) begin : g_nb
         assign below = 1'b0;
      end else begin : g_b
         assign below = bank_open[H*HALF + K - 1];
      end
      if (K == HALF) begin : g_na
         assign above = 1'b0;
      end else begin : g_a
         assign above = bank_open[H*HALF + K];
      end
      assign sa_used[a] = below | above;
      assign sa_hi[a]   = above;
   end
endmodule

// File: rtl/bank_sa_tracker.sv
module bank_sa_tracker
   import bt_pkg::*;
#(
   parameter int unsigned NUM_BANKS  = 32,
   parameter int unsigned ROW_W      = 10,
   parameter int unsigned T_RC       = 28,
   parameter int unsigned T_RAS      = 20,
   parameter int unsigned T_RP       = 8,
   parameter int unsigned T_RR       = 8,
   parameter int unsigned T_PP       = 8,
   parameter int unsigned T_OPEN_MAX = 25600
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_vld,
   input  logic                         cmd_act,
   input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
   input  logic [ROW_W-1:0]             cmd_row,
   input  logic [$clog2(NUM_BANKS)-1:0] qry_bank,
   output logic [NUM_BANKS-1:0]         bank_open,
   output logic [ROW_W-1:0]             qry_open_row,
   output logic [NUM_BANKS+1:0]         sa_used,
   output logic [NUM_BANKS+1:0]         sa_hi,
   output logic                         viol_vld,
   output logic [3:0]                   viol_code,
   output logic [$clog2(NUM_BANKS)-1:0] viol_bank,
   output logic                         tmo_vld,
   output logic [$clog2(NUM_BANKS)-1:0] tmo_bank
);
   localparam int unsigned BANK_W  = $clog2(NUM_BANKS);
   localparam int unsigned CNT_SAT = T_OPEN_MAX + 1;
   localparam int unsigned CNT_W   = $clog2(CNT_SAT + 1);

   if (NUM_BANKS < 4 || NUM_BANKS % 2 != 0 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 4");
   end
   if (T_RC == 0 || T_RAS == 0 || T_RP == 0 || T_RR == 0 || T_PP == 0) begin : g_bad_zero
      $error("timing limits must be non-zero");
   end
   if (T_OPEN_MAX <= T_RC || T_OPEN_MAX <= T_RAS || T_OPEN_MAX <= T_RP ||
       T_OPEN_MAX <= T_RR || T_OPEN_MAX <= T_PP) begin : g_bad_open
      $error("T_OPEN_MAX must exceed every other timing limit");
   end

   logic [NUM_BANKS-1:0] open_v, nbr_busy, do_act, do_pre;
   logic [ROW_W-1:0]     row_q     [NUM_BANKS];
   logic [CNT_W-1:0]     since_act [NUM_BANKS];
   logic [CNT_W-1:0]     since_pre [NUM_BANKS];
   logic [CNT_W-1:0]     gap_act, gap_pre;
   logic                 tgt_open, tgt_nbr, act_ok, pre_ok;
   viol_e                code_c;
   logic                 tmo_hit;
   logic [BANK_W-1:0]    tmo_idx;

   assign tgt_open = open_v[cmd_bank];
   assign tgt_nbr  = nbr_busy[cmd_bank];
   assign act_ok   = cmd_vld &  cmd_act & ~tgt_open & ~tgt_nbr;
   assign pre_ok   = cmd_vld & ~cmd_act &  tgt_open;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_slot
      assign do_act[b] = act_ok && (cmd_bank == BANK_W'(b));
      assign do_pre[b] = pre_ok && (cmd_bank == BANK_W'(b));
      bt_bank_slot #(.ROW_W(ROW_W), .SAT(CNT_SAT), .W(CNT_W)) u_slot (
         .clk(clk), .rst_n(rst_n), .do_act(do_act[b]), .do_pre(do_pre[b]),
         .row_in(cmd_row), .is_open(open_v[b]), .row_q(row_q[b]),
         .since_act(since_act[b]), .since_pre(since_pre[b]));
   end

   bt_interval #(.SAT(CNT_SAT), .W(CNT_W)) u_gap_act (
      .clk(clk), .rst_n(rst_n), .restart(act_ok), .count(gap_act));
   bt_interval #(.SAT(CNT_SAT), .W(CNT_W)) u_gap_pre (
      .clk(clk), .rst_n(rst_n), .restart(pre_ok), .count(gap_pre));

   bt_amp_map #(.NUM_BANKS(NUM_BANKS)) u_amp (
      .bank_open(open_v), .nbr_busy(nbr_busy), .sa_used(sa_used), .sa_hi(sa_hi));

   // Rule priority: lowest code first.
   always_comb begin
      code_c = V_NONE;
      if (cmd_vld && cmd_act) begin
         if (tgt_open)                                   code_c = V_REOPEN;
         else if (tgt_nbr)                               code_c = V_NEIGH;
         else if (since_pre[cmd_bank] < CNT_W'(T_RP))    code_c = V_TRP;
         else if (since_act[cmd_bank] < CNT_W'(T_RC))    code_c = V_TRC;
         else if (gap_act < CNT_W'(T_RR))                code_c = V_TRR;
      end else if (pre_ok) begin
         if (since_act[cmd_bank] < CNT_W'(T_RAS))        code_c = V_TRAS;
         else if (gap_pre < CNT_W'(T_PP))                code_c = V_TPP;
      end
   end

   // Lowest-index bank that has just reached the open limit.
   always_comb begin
      tmo_hit = 1'b0;
      tmo_idx = '0;
      for (int i = NUM_BANKS - 1; i >= 0; i--) begin
         if (open_v[i] && since_act[i] == CNT_W'(T_OPEN_MAX)) begin
            tmo_hit = 1'b1;
            tmo_idx = BANK_W'(i);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol_vld  <= 1'b0;
         viol_code <= '0;
         viol_bank <= '0;
         tmo_vld   <= 1'b0;
         tmo_bank  <= '0;
      end else begin
         viol_vld  <= (code_c != V_NONE);
         viol_code <= code_c;
         viol_bank <= cmd_bank;
         tmo_vld   <= tmo_hit;
         tmo_bank  <= tmo_idx;
      end
   end

   assign bank_open    = open_v;
   assign qry_open_row = row_q[qry_bank];
endmodule

// File: rtl/bank_sa_tracker_chk.sv
module bank_sa_tracker_chk #(
   parameter int unsigned NUM_BANKS = 32,
   parameter int unsigned ROW_W     = 10
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         cmd_vld,
   input logic                         cmd_act,
   input logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
   input logic [$clog2(NUM_BANKS)-1:0] qry_bank,
   input logic [NUM_BANKS-1:0]         bank_open,
   input logic [ROW_W-1:0]             qry_open_row,
   input logic [NUM_BANKS+1:0]         sa_used,
   input logic                         viol_vld,
   input logic [3:0]                   viol_code,
   input logic                         tmo_vld,
   input logic [$clog2(NUM_BANKS)-1:0] tmo_bank
);
   localparam int unsigned HALF = NUM_BANKS / 2;

   function automatic logic [NUM_BANKS-1:0] pair_mask();
      logic [NUM_BANKS-1:0] m;
      for (int i = 0; i < NUM_BANKS; i++) m[i] = ((i % HALF) != HALF - 1);
      return m;
   endfunction
   localparam logic [NUM_BANKS-1:0] PAIRS = pair_mask();

   logic [NUM_BANKS-1:0] open_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) open_d <= '0;
      else        open_d <= bank_open;
   end

   AST_NO_ADJ_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      ((bank_open & (bank_open >> 1) & PAIRS) == '0)); // R4
   AST_REOPEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd_act && bank_open[cmd_bank]) |=> (viol_vld && viol_code == 4'd1)); // R3
   AST_REOPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd_act && bank_open[cmd_bank] && qry_bank == cmd_bank)
      |=> ($stable(qry_bank) |-> $stable(qry_open_row))); // R3
   AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && !cmd_act) |=> !bank_open[$past(cmd_bank)]); // R5
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_vld |=> !viol_vld); // R14
   AST_SA_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(sa_used) <= 2 * $countones(bank_open))); // R13
   AST_TMO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_vld |-> open_d[tmo_bank]); // R12
endmodule

bind bank_sa_tracker bank_sa_tracker_chk #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_chk (.*);

// File: tb/tb_bank_sa_tracker.sv
module tb_bank_sa_tracker;
   localparam int NB = 32, RW = 10, H = NB / 2;
   localparam int TRC = 32, TRAS = 20, TRP = 8, TRR = 8, TPP = 8, TMAX = 300;
   localparam int SAT = TMAX + 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cmd_vld = 1'b0, cmd_act = 1'b0;
   logic [4:0] cmd_bank = '0, qry_bank = '0;
   logic [RW-1:0] cmd_row = '0;
   logic [NB-1:0] bank_open;
   logic [RW-1:0] qry_open_row;
   logic [NB+1:0] sa_used, sa_hi;
   logic viol_vld, tmo_vld;
   logic [3:0] viol_code;
   logic [4:0] viol_bank, tmo_bank;

   bank_sa_tracker #(.NUM_BANKS(NB), .ROW_W(RW), .T_RC(TRC), .T_RAS(TRAS), .T_RP(TRP),
      .T_RR(TRR), .T_PP(TPP), .T_OPEN_MAX(TMAX)) dut (.*);

   always #10 clk = ~clk;

   int checks = 0, failures = 0, tmo_seen = 0;
   bit m_open[NB];
   int m_row[NB], m_sa[NB], m_sp[NB];
   int g_a, g_p;

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(input int c);
      case (c)
         1: return "R3";  2: return "R4";  3: return "R6";  4: return "R7";
         5: return "R8";  6: return "R9";  7: return "R10"; default: return "R14";
      endcase
   endfunction

   function automatic bit nbr(input int b);
      int j = b % H;
      return (j > 0 && m_open[b-1]) || (j < H - 1 && m_open[b+1]);
   endfunction

   function automatic int exp_code(input bit act, input int b);
      if (act) begin
         if (m_open[b]) return 1;
         if (nbr(b)) return 2;
         if (m_sp[b] < TRP) return 3;
         if (m_sa[b] < TRC) return 4;
         if (g_a < TRR) return 5;
      end else if (m_open[b]) begin
         if (m_sa[b] < TRAS) return 6;
         if (g_p < TPP) return 7;
      end
      return 0;
   endfunction

   function automatic int inc(input int v);
      return (v >= SAT) ? SAT : v + 1;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < NB; i++) begin
         m_open[i] = 0; m_row[i] = 0; m_sa[i] = SAT; m_sp[i] = SAT;
      end
      g_a = SAT; g_p = SAT;
   endtask

   task automatic check_sa();
      logic [NB+1:0] eu, eh;
      eu = '0; eh = '0;
      for (int b = 0; b < NB; b++) begin
         int base = (b / H) * (H + 1) + (b % H);
         if (m_open[b]) begin
            eu[base] = 1'b1; eh[base] = 1'b1; eu[base+1] = 1'b1;
         end
      end
      chk(sa_used == eu, "R13", "sa_used", int'(sa_used[31:0]), int'(eu[31:0]));
      chk(sa_hi == eh, "R13", "sa_hi", int'(sa_hi[31:0]), int'(eh[31:0]));
   endtask

   int last_code;

   task automatic step(input bit vld, input bit act, input int b, input int row);
      int ec, etb;
      bit et, acc_a, acc_p;
      logic [NB-1:0] eo;
      cmd_vld = vld; cmd_act = act; cmd_bank = 5'(b); cmd_row = RW'(row); qry_bank = 5'(b);
      ec = vld ? exp_code(act, b) : 0;
      et = 0; etb = 0;
      for (int i = NB - 1; i >= 0; i--)
         if (m_open[i] && m_sa[i] == TMAX) begin et = 1; etb = i; end
      acc_a = vld && act && !m_open[b] && !nbr(b);
      acc_p = vld && !act && m_open[b];
      for (int i = 0; i < NB; i++) begin
         m_sa[i] = (acc_a && i == b) ? 1 : inc(m_sa[i]);
         m_sp[i] = (acc_p && i == b) ? 1 : inc(m_sp[i]);
      end
      if (acc_a) begin m_open[b] = 1; m_row[b] = row; end
      if (acc_p) m_open[b] = 0;
      g_a = acc_a ? 1 : inc(g_a);
      g_p = acc_p ? 1 : inc(g_p);
      @(posedge clk); @(negedge clk);
      last_code = ec;
      chk(viol_vld == (ec != 0), tag_of(ec), "viol_vld", int'(viol_vld), int'(ec != 0));
      if (ec != 0) begin
         chk(int'(viol_code) == ec, tag_of(ec), "viol_code", int'(viol_code), ec);
         chk(int'(viol_bank) == b, "R14", "viol_bank", int'(viol_bank), b);
      end
      chk(tmo_vld == et, "R12", "tmo_vld", int'(tmo_vld), int'(et));
      if (et) chk(int'(tmo_bank) == etb, "R12", "tmo_bank", int'(tmo_bank), etb);
      if (tmo_vld && tmo_bank == 5'd30) tmo_seen++;
      for (int i = 0; i < NB; i++) eo[i] = m_open[i];
      chk(bank_open == eo, "R5", "bank_open", int'(bank_open), int'(eo));
      if (m_open[b]) chk(int'(qry_open_row) == m_row[b], "R2", "qry_open_row", int'(qry_open_row), m_row[b]);
      check_sa();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0);
   endtask

   task automatic want(input int code, input string tag);
      chk(int'(viol_code) == code && viol_vld == (code != 0), tag, "directed code",
          viol_vld ? int'(viol_code) : 0, code);
   endtask

   initial begin
      #(200000 * 20);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(bank_open == '0, "R1", "reset bank_open", int'(bank_open), 0);
      chk(!viol_vld && !tmo_vld, "R1", "reset pulses", int'(viol_vld), 0);
      chk(sa_used == '0, "R1", "reset sa_used", int'(sa_used[31:0]), 0);

      step(1, 1, 3, 'h155);  want(0, "R1");
      chk(bank_open[3] && qry_open_row == 10'h155, "R2", "opened row", int'(qry_open_row), 'h155);
      idle(7);
      step(1, 1, 3, 'h0AA);  want(1, "R3");
      chk(qry_open_row == 10'h155, "R3", "row unchanged", int'(qry_open_row), 'h155);
      step(1, 1, 4, 'h001);  want(2, "R4");
      chk(!bank_open[4], "R4", "rejected bank stays closed", int'(bank_open[4]), 0);
      idle(7);
      step(1, 1, 15, 'h011); want(0, "R4");
      idle(7);
      step(1, 1, 16, 'h022); want(0, "R4");
      step(1, 0, 15, 0);     want(6, "R9");
      chk(!bank_open[15], "R9", "closes despite tRAS", int'(bank_open[15]), 0);
      step(1, 0, 16, 0);     want(6, "R11");
      step(1, 0, 3, 0);      want(7, "R10");
      step(1, 0, 3, 0);      want(0, "R5");
      step(1, 1, 3, 'h033);  want(3, "R6");
      chk(bank_open[3], "R6", "opens despite tRP", int'(bank_open[3]), 1);
      idle(40);
      step(1, 1, 25, 'h044); want(0, "R2");
      idle(19);
      step(1, 0, 25, 0);     want(0, "R9");
      idle(7);
      step(1, 1, 25, 'h055); want(4, "R7");
      idle(10);
      step(1, 1, 5, 'h066);  want(0, "R2");
      idle(2);
      step(1, 1, 8, 'h077);  want(5, "R8");
      foreach (m_open[i]) if (m_open[i]) begin idle(8); step(1, 0, i, 0); end
      idle(8);
      step(1, 1, 30, 'h3FF); want(0, "R2");
      chk(sa_used == (34'd1 << 31 | 34'd1 << 32) && sa_hi == 34'd1 << 31, "R13",
          "amps of bank 30", int'(sa_used[31:0]), int'(32'h8000_0000));
      tmo_seen = 0;
      idle(TMAX + 20);
      chk(tmo_seen == 1, "R12", "single timeout pulse", tmo_seen, 1);
      step(1, 0, 30, 0);

      for (int n = 0; n < 4000; n++) begin
         int b;
         b = ($urandom % 2) ? 12 + int'($urandom % 8) : int'($urandom % NB);
         step(($urandom % 4) != 0, $urandom % 2, b, int'($urandom % 1024));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule